// File: doc/BRIEF.md
# Execute Packet Dispatcher

The dispatcher sits between instruction fetch and the eight functional units of a wide-issue core. Fetch delivers 256-bit fetch packets of eight 32-bit instruction words. The dispatcher cuts each fetch packet into execute packets, which are runs of consecutive words chained by a per-word link bit. It then issues every execute packet in a single cycle. Each word goes onto the output lane of the unit it names. Four unit classes exist: arithmetic, shift/branch, multiply and data. Each class has one unit on each of the two datapath sides.

A mode input picks how packet boundaries are treated. In fenced mode, an execute packet always ends at the last word of its fetch packet. Padding NOP words that trail the last real execute packet cost no cycle. In spanning mode, an execute packet still open at the last word is held back and completed with the leading words of the next fetch packet. While words of the current fetch packet remain to be issued, the fetch handshake stalls. The next fetch packet is accepted in the cycle its predecessor finishes, so dense code issues one execute packet every cycle.

Top module: `vliw_ep_dispatch`

## Requirements
- R1: After reset, `fp_ready` is 1, `issue_valid` is all zero and `conflict` is 0.
- R2: The fields of each word are used as follows. Bit 0 is the link bit: 1 chains the next word into the same execute packet and 0 closes the packet. Bits 3:1 give the unit: 0=L1, 1=L2, 2=S1, 3=S2, 4=M1, 5=M2, 6=D1, 7=D2. A packet's words appear together for one cycle, word unchanged, as `issue_valid[u]` and `issue_op[32*u +: 32]`. The first packet of a fetch packet appears in the cycle after the handshake edge, and each later packet one cycle after the previous one.
- R3: A word whose bits 31:1 are all zero is a NOP. It is never issued, but its bit 0 still links or closes the packet.
- R4: `fp_ready` is 0 while the held fetch packet still has execute packets left to issue. It is 1 while nothing is held.
- R5: A new fetch packet is accepted on the same edge that issues the last execute packet of the previous one, so dense code has no idle cycle between fetch packets.
- R6: In fenced mode (`span_mode`=0), word 7 always closes its execute packet, whatever its link bit.
- R7: In fenced mode, NOP words that follow the last execute packet of a fetch packet are skipped without spending a cycle.
- R8: In spanning mode (`span_mode`=1), an execute packet that is still linked at word 7 issues nothing until the next fetch packet arrives. It is then issued in one cycle together with that packet's leading chained words.
- R9: If two words of one execute packet name the same unit, only the earlier word is issued on that lane, and `conflict` is 1 in that issue cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| span_mode | input | 1 | 0 fenced, 1 spanning; held steady while packets are in flight |
| fp_valid | input | 1 | Fetch packet offered |
| fp_data | input | 256 | Fetch packet, word k at bits 32k+31:32k |
| fp_ready | output | 1 | Fetch packet accepted when high together with fp_valid |
| issue_valid | output | 8 | Per-unit issue strobe, bit u for unit u |
| issue_op | output | 256 | Per-unit instruction word, lane u at bits 32u+31:32u |
| conflict | output | 1 | Two words of the issued packet named the same unit |

## Verification
The bench builds the block at its default shape: eight 32-bit words per fetch packet and a 3-bit unit field, which gives eight lanes. This shape lets every word position hold a unit of its own. Fully serial, fully parallel and mixed link patterns can then drive each lane alone or all eight at once. Because word 7 is reachable with its link bit set, the same fetch packet pair can be run in both modes, which contrasts the fenced cut with the spanning merge. Back-to-back fetch streams at this size show whether the dispatcher keeps one issue per cycle across fetch packet boundaries.

// File: rtl/vliw_disp_pkg.sv
// Package: shared constants for the execute packet dispatcher.
// Assumes every instruction word keeps its link bit at bit 0 and its unit
// field directly above it.
package vliw_disp_pkg;

    localparam int PAR_BIT  = 0;
    localparam int UNIT_LSB = 1;

    typedef enum logic {
        MODE_FENCED = 1'b0,
        MODE_SPAN   = 1'b1
    } pack_mode_e;

endpackage

// File: rtl/vliw_fp_buffer.sv
// Fetch packet holding register with a word pointer.
// Loads a new packet on a handshake, and otherwise either moves the pointer
// to the next execute packet or empties itself once the packet is used up.
// Assumes load is only raised while the buffer is empty or finishing.
module vliw_fp_buffer #(
    parameter int SLOTS = 8,
    parameter int IW    = 32,
    localparam int PTR_W = $clog2(SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [SLOTS*IW-1:0]   load_data,
    input  logic                  buf_done,
    input  logic [PTR_W-1:0]      next_ptr,
    output logic [SLOTS*IW-1:0]   words,
    output logic [PTR_W-1:0]      ptr,
    output logic                  full
);

    // Packet storage, pointer and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words <= '0;
            ptr   <= '0;
            full  <= 1'b0;
        end else if (load) begin
            words <= load_data;
            ptr   <= '0;
            full  <= 1'b1;
        end else if (full && buf_done) begin
            full  <= 1'b0;
        end else if (full) begin
            ptr   <= next_ptr;
        end
    end

endmodule

// File: rtl/vliw_ep_chain.sv
// Execute packet boundary finder.
// Starting at the pointer, marks the run of words linked by their link bits.
// In fenced mode the run is cut at the last word, and the packet counts as
// used up when only NOPs remain after the run. Purely combinational.
module vliw_ep_chain
    import vliw_disp_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int IW    = 32,
    localparam int PTR_W = $clog2(SLOTS)
) (
    input  logic [SLOTS*IW-1:0] words,
    input  logic [PTR_W-1:0]    ptr,
    input  logic                span_mode,
    output logic [SLOTS-1:0]    take,
    output logic [PTR_W-1:0]    next_ptr,
    output logic                buf_done,
    output logic                open_tail
);

    logic             alive;
    logic             rest_nop;
    logic [PTR_W-1:0] last;

    // Walk the link bits from the pointer and mark the packet's words.
    always_comb begin
        alive = 1'b1;
        take  = '0;
        last  = ptr;
        for (int i = 0; i < SLOTS; i++) begin
            if (PTR_W'(i) >= ptr && alive) begin
                take[i] = 1'b1;
                last    = PTR_W'(i);
                if (!words[i*IW + PAR_BIT]) alive = 1'b0;
            end
        end
    end

    // Check whether only NOP words remain past the packet.
    always_comb begin
        rest_nop = 1'b1;
        for (int i = 0; i < SLOTS; i++) begin
            if (PTR_W'(i) > last && words[i*IW + 1 +: IW-1] != '0) rest_nop = 1'b0;
        end
    end

    // Derive the packet end, the buffer exhaustion and the spanning tail.
    always_comb begin
        open_tail = take[SLOTS-1] & words[(SLOTS-1)*IW + PAR_BIT]
                    & (span_mode == MODE_SPAN);
        buf_done  = take[SLOTS-1] | ((span_mode == MODE_FENCED) & rest_nop);
        next_ptr  = last + 1'b1;
    end

endmodule

// File: rtl/vliw_unit_xbar.sv
// Slot-to-unit crossbar with conflict detection.
// Places each taken non-NOP word on the lane its unit field names, on top of
// lanes carried in from an earlier fetch packet. On a clash the earlier word
// keeps the lane and the conflict output rises. Purely combinational.
module vliw_unit_xbar
    import vliw_disp_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int IW     = 32,
    parameter int UNIT_W = 3,
    localparam int NUNITS = 1 << UNIT_W
) (
    input  logic [SLOTS*IW-1:0]  words,
    input  logic [SLOTS-1:0]     take,
    input  logic [NUNITS-1:0]    carry_valid,
    input  logic [NUNITS*IW-1:0] carry_op,
    input  logic                 carry_conf,
    output logic [NUNITS-1:0]    lane_valid,
    output logic [NUNITS*IW-1:0] lane_op,
    output logic                 lane_conf
);

    logic [UNIT_W-1:0] u;

    // Merge the taken words in slot order onto the unit lanes.
    always_comb begin
        lane_valid = carry_valid;
        lane_op    = carry_op;
        lane_conf  = carry_conf;
        u          = '0;
        for (int i = 0; i < SLOTS; i++) begin
            u = words[i*IW + UNIT_LSB +: UNIT_W];
            if (take[i] && words[i*IW + 1 +: IW-1] != '0) begin
                if (lane_valid[u]) begin
                    lane_conf = 1'b1;
                end else begin
                    lane_valid[u]         = 1'b1;
                    lane_op[u*IW +: IW]   = words[i*IW +: IW];
                end
            end
        end
    end

endmodule

// File: rtl/vliw_ep_dispatch.sv
// Execute packet dispatcher top.
// Holds one fetch packet and issues one execute packet per cycle onto
// registered per-unit lanes. In spanning mode, a packet still linked at the
// last word is parked in carry registers until the next fetch packet
// completes it. Assumes span_mode changes only while the block is idle.
module vliw_ep_dispatch
    import vliw_disp_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int IW     = 32,
    parameter int UNIT_W = 3,
    localparam int NUNITS = 1 << UNIT_W,
    localparam int PTR_W  = $clog2(SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  span_mode,
    input  logic                  fp_valid,
    input  logic [SLOTS*IW-1:0]   fp_data,
    output logic                  fp_ready,
    output logic [NUNITS-1:0]     issue_valid,
    output logic [NUNITS*IW-1:0]  issue_op,
    output logic                  conflict
);

    logic [SLOTS*IW-1:0]  words;
    logic [PTR_W-1:0]     ptr;
    logic                 full;
    logic [SLOTS-1:0]     take;
    logic [PTR_W-1:0]     next_ptr;
    logic                 buf_done;
    logic                 open_tail;
    logic [NUNITS-1:0]    carry_valid;
    logic [NUNITS*IW-1:0] carry_op;
    logic                 carry_conf;
    logic [NUNITS-1:0]    lane_valid;
    logic [NUNITS*IW-1:0] lane_op;
    logic                 lane_conf;

    // Accept fetch when empty or when the held packet finishes this cycle.
    assign fp_ready = ~full | buf_done;

    vliw_fp_buffer #(.SLOTS(SLOTS), .IW(IW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (fp_valid & fp_ready),
        .load_data (fp_data),
        .buf_done  (buf_done),
        .next_ptr  (next_ptr),
        .words     (words),
        .ptr       (ptr),
        .full      (full)
    );

    vliw_ep_chain #(.SLOTS(SLOTS), .IW(IW)) u_chain (
        .words     (words),
        .ptr       (ptr),
        .span_mode (span_mode),
        .take      (take),
        .next_ptr  (next_ptr),
        .buf_done  (buf_done),
        .open_tail (open_tail)
    );

    vliw_unit_xbar #(.SLOTS(SLOTS), .IW(IW), .UNIT_W(UNIT_W)) u_xbar (
        .words       (words),
        .take        (take),
        .carry_valid (carry_valid),
        .carry_op    (carry_op),
        .carry_conf  (carry_conf),
        .lane_valid  (lane_valid),
        .lane_op     (lane_op),
        .lane_conf   (lane_conf)
    );

    // Register the issued packet, or park an open tail in the carry lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_valid <= '0;
            issue_op    <= '0;
            conflict    <= 1'b0;
            carry_valid <= '0;
            carry_op    <= '0;
            carry_conf  <= 1'b0;
        end else if (full && open_tail) begin
            issue_valid <= '0;
            conflict    <= 1'b0;
            carry_valid <= lane_valid;
            carry_op    <= lane_op;
            carry_conf  <= lane_conf;
        end else if (full) begin
            issue_valid <= lane_valid;
            issue_op    <= lane_op;
            conflict    <= lane_conf;
            carry_valid <= '0;
            carry_op    <= '0;
            carry_conf  <= 1'b0;
        end else begin
            issue_valid <= '0;
            conflict    <= 1'b0;
        end
    end

endmodule

// File: rtl/vliw_ep_dispatch_chk.sv
// Assertion checker for the execute packet dispatcher, bound to the top.
// Observes ports only.
module vliw_ep_dispatch_chk #(
    parameter int SLOTS  = 8,
    parameter int IW     = 32,
    parameter int UNIT_W = 3,
    localparam int NUNITS = 1 << UNIT_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fp_valid,
    input logic                 fp_ready,
    input logic [NUNITS-1:0]    issue_valid,
    input logic [NUNITS*IW-1:0] issue_op,
    input logic                 conflict
);

    // R1: the first cycle after reset issues nothing and flags nothing.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (issue_valid == '0 && !conflict));

    // R4: an idle, ready dispatcher with no offer stays ready.
    p_idle_stays_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_ready && !fp_valid) |=> fp_ready);

    // R9: a conflict is always reported along with the surviving issue.
    p_conflict_with_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> (issue_valid != '0));

    for (genvar u = 0; u < NUNITS; u++) begin : g_lane
        // R2: a lane only carries words that name that lane's unit.
        p_lane_unit_r2: assert property (@(posedge clk) disable iff (!rst_n)
            issue_valid[u] |-> (issue_op[u*IW + 1 +: UNIT_W] == UNIT_W'(u)));
        // R3: a NOP word never reaches a lane.
        p_no_nop_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
            issue_valid[u] |-> (issue_op[u*IW + 1 +: IW-1] != '0));
    end

endmodule

bind vliw_ep_dispatch vliw_ep_dispatch_chk #(
    .SLOTS(SLOTS), .IW(IW), .UNIT_W(UNIT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fp_valid    (fp_valid),
    .fp_ready    (fp_ready),
    .issue_valid (issue_valid),
    .issue_op    (issue_op),
    .conflict    (conflict)
);

// File: tb/tb_vliw_ep_dispatch.sv
// Self-checking bench for the execute packet dispatcher.
module tb_vliw_ep_dispatch;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;

    // Table: per-word unit (3 bits per word), link bits, NOP marks,
    // expected issue masks in order (event e at bits 8e+7:8e), event count.
    localparam logic [23:0] V_UNIT [NV] = '{24'hFAC688, 24'hFAC688, 24'h688FAC,
        24'h00001A, 24'hFAC688, 24'hFAC688, 24'hF9A141};
    localparam logic [7:0]  V_PAR  [NV] = '{8'h7F, 8'h00, 8'h77, 8'hFB, 8'hFF, 8'h55, 8'h7B};
    localparam logic [7:0]  V_NOP  [NV] = '{8'h00, 8'h00, 8'h00, 8'hF8, 8'h00, 8'h00, 8'h02};
    localparam logic [63:0] V_MASK [NV] = '{64'hFF, 64'h8040201008040201, 64'h0FF0,
        64'h0D, 64'hFF, 64'hC0300C03, 64'hCD22};
    localparam int          V_CNT  [NV] = '{1, 8, 2, 1, 1, 4, 2};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         span_mode = 1'b0;
    logic         fp_valid = 1'b0;
    logic [255:0] fp_data = '0;
    logic         fp_ready;
    logic [7:0]   issue_valid;
    logic [255:0] issue_op;
    logic         conflict;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int n_ev = 0;
    logic [7:0]   ev_mask [16];
    logic         ev_conf [16];
    int           ev_cyc  [16];
    logic [255:0] ev_op   [16];

    vliw_ep_dispatch dut (
        .clk(clk), .rst_n(rst_n), .span_mode(span_mode), .fp_valid(fp_valid),
        .fp_data(fp_data), .fp_ready(fp_ready), .issue_valid(issue_valid),
        .issue_op(issue_op), .conflict(conflict)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record every cycle that issues or flags, sampled at the falling edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && (issue_valid != '0 || conflict) && n_ev < 16) begin
            ev_mask[n_ev] = issue_valid;
            ev_conf[n_ev] = conflict;
            ev_cyc[n_ev]  = cyc;
            ev_op[n_ev]   = issue_op;
            n_ev = n_ev + 1;
        end
    end

    function automatic logic [255:0] build(int vid, logic [23:0] un, logic [7:0] pa, logic [7:0] np);
        logic [255:0] w;
        for (int s = 0; s < 8; s++) begin
            if (np[s]) w[s*32 +: 32] = {31'b0, pa[s]};
            else       w[s*32 +: 32] = {12'hA5C, 8'(vid), 8'(s), un[3*s +: 3], pa[s]};
        end
        return w;
    endfunction

    function automatic string vtag(int v);
        if (v == 3) return "R7";
        if (v == 4) return "R6";
        if (v == 6) return "R3";
        return "R2";
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Offer one fetch packet, starting at a falling edge, until accepted.
    task automatic send(input logic [255:0] d);
        fp_data  = d;
        fp_valid = 1'b1;
        while (!fp_ready) @(negedge clk);
        @(negedge clk);
        fp_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [255:0] pa, pb, pc, p0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        chk("R1 ready", 64'(fp_ready), 64'd1);
        chk("R1 issue", 64'(issue_valid), 64'd0);
        chk("R1 conflict", 64'(conflict), 64'd0);

        // Table walk, fenced mode.
        for (int v = 0; v < NV; v++) begin
            n_ev = 0;
            send(build(v, V_UNIT[v], V_PAR[v], V_NOP[v]));
            if (v == 1) chk("R4 stall while draining", 64'(fp_ready), 64'd0);
            idle(14);
            chk({vtag(v), " count"}, 64'(n_ev), 64'(V_CNT[v]));
            for (int e = 0; e < V_CNT[v] && e < n_ev; e++)
                chk({vtag(v), " mask"}, 64'(ev_mask[e]), 64'(V_MASK[v][8*e +: 8]));
        end
        chk("R4 ready when empty", 64'(fp_ready), 64'd1);

        // R5/R7: back-to-back stream issues on consecutive cycles.
        n_ev = 0;
        p0 = build(0, V_UNIT[0], V_PAR[0], V_NOP[0]);
        send(build(3, V_UNIT[3], V_PAR[3], V_NOP[3]));
        send(p0);
        send(build(2, V_UNIT[2], V_PAR[2], V_NOP[2]));
        send(build(2, V_UNIT[2], V_PAR[2], V_NOP[2]));
        idle(12);
        chk("R5 count", 64'(n_ev), 64'd6);
        chk("R7 mask0", 64'(ev_mask[0]), 64'h0D);
        chk("R5 mask1", 64'(ev_mask[1]), 64'hFF);
        chk("R5 mask4", 64'(ev_mask[4]), 64'hF0);
        for (int e = 1; e < 6; e++)
            chk("R5 no bubble", 64'(ev_cyc[e] - ev_cyc[e-1]), 64'd1);
        for (int u = 0; u < 8; u++)
            chk("R2 lane word", 64'(ev_op[1][u*32 +: 32]), 64'(p0[u*32 +: 32]));

        // Spanning pair A/B: A links past its last word.
        pa = build(10, 24'hFAC688, 8'hDF, 8'h00);
        pb = build(11, 24'h000088, 8'h01, 8'hF8);

        // R6: fenced mode cuts at word 7.
        n_ev = 0;
        send(pa); idle(5); send(pb); idle(10);
        chk("R6 count", 64'(n_ev), 64'd4);
        chk("R6 mask0", 64'(ev_mask[0]), 64'h3F);
        chk("R6 mask1", 64'(ev_mask[1]), 64'hC0);
        chk("R6 mask2", 64'(ev_mask[2]), 64'h03);
        chk("R6 mask3", 64'(ev_mask[3]), 64'h04);

        // R8: spanning mode merges the tail with the next packet.
        span_mode = 1'b1;
        n_ev = 0;
        send(pa); idle(5);
        chk("R8 tail held", 64'(n_ev), 64'd1);
        send(pb); idle(10);
        chk("R8 count", 64'(n_ev), 64'd3);
        chk("R8 mask0", 64'(ev_mask[0]), 64'h3F);
        chk("R8 merged mask", 64'(ev_mask[1]), 64'hC3);
        chk("R8 mask2", 64'(ev_mask[2]), 64'h04);
        chk("R8 lane6 from A", 64'(ev_op[1][6*32 +: 32]), 64'(pa[6*32 +: 32]));
        chk("R8 lane0 from B", 64'(ev_op[1][0 +: 32]), 64'(pb[0 +: 32]));
        span_mode = 1'b0;

        // R9: two words name unit M1 (4).
        n_ev = 0;
        pc = build(12, 24'h000024, 8'hFD, 8'hFC);
        send(pc); idle(8);
        chk("R9 count", 64'(n_ev), 64'd1);
        chk("R9 mask", 64'(ev_mask[0]), 64'h10);
        chk("R9 flag", 64'(ev_conf[0]), 64'd1);
        chk("R9 first kept", 64'(ev_op[0][4*32 +: 32]), 64'(pc[0 +: 32]));

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule